// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Sequencer

This block sits in a DRAM controller and owns the clock-enable and command pins of a synchronous graphics DRAM during self-refresh transitions. An entry request puts the device into self-refresh. An exit request brings it back out once the device has spent its minimum time in self-refresh and the system clock is reported stable. While the sequencer is in any state other than idle, it tells the rest of the controller that it owns the pins.

A system that refreshes in bursts needs a block of back-to-back auto-refresh commands on both sides of the self-refresh period. The refresh-style input is sampled when a sequence starts, and that choice holds for both the entry burst and the exit burst. Commands in a burst are spaced by the row-cycle time. All time limits are parameters counted in clock cycles: `T_RAS`, `T_SRX`, `T_RC` and `BURST_LEN`. The exit window lasts `T_EXIT = max(T_SRX, T_RC)`.

Pin encodings are given as (cke, cs_n, ras_n, cas_n, we_n). Deselect is CKE high with CS high. Auto-refresh is (1,0,0,0,1). The self-refresh entry command is (0,0,0,0,1).

Top module: `sr_seq`

## Requirements
- R1: After reset, cke_o is 1, cs_no is 1, ready_o is 1 and busy_o is 0.
- R2: With burst_mode_i low, an entry request sampled at a clock edge produces the entry command (0,0,0,0,1) in the very next cycle, and that command lasts exactly one cycle.
- R3: After the entry cycle, cke_o stays 0 and cs_no is parked at 1 for as long as no exit is allowed.
- R4: cke_o stays low for at least T_RAS+1 cycles, counting the entry cycle. If the exit is already pending and clk_stable_i is high, cke_o is low for exactly T_RAS+1 cycles.
- R5: Exit does not begin while clk_stable_i is 0. An exit request is remembered until then, and cke_o rises one cycle after clk_stable_i is sampled high.
- R6: From the cycle cke_o rises, cs_no stays 1 for T_EXIT cycles. No command is issued and ready_o stays 0 in that window. In the non-burst case, ready_o rises exactly T_EXIT cycles after cke_o rises.
- R7: With burst_mode_i high at the start, exactly BURST_LEN auto-refresh commands precede entry, spaced exactly T_RC cycles apart, and the entry command follows T_RC cycles after the last one. After exit, exactly BURST_LEN more follow: the first comes T_EXIT cycles after cke_o rises, and ready_o rises T_RC cycles after the last.
- R8: The only command issued while cke_o is high is auto-refresh (cs/ras/cas low, we high).
- R9: An entry request that arrives while the sequencer is not idle is held. It starts a new sequence on return to idle, with no further request needed.
- R10: An exit request while the device is not in self-refresh has no effect: cke_o stays 1, and a later self-refresh period does not end without a new exit request.
- R11: busy_o is 1 and ready_o is 0 in every non-idle state, including every burst, entry, self-refresh and exit cycle.
- R12: The refresh style is latched when a sequence starts. Lowering burst_mode_i during the sequence does not remove the exit burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enter_req_i | input | 1 | Request to enter self-refresh |
| exit_req_i | input | 1 | Request to leave self-refresh |
| burst_mode_i | input | 1 | System uses burst refresh |
| clk_stable_i | input | 1 | System clock is running and stable |
| cke_o | output | 1 | DRAM clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ready_o | output | 1 | Sequencer idle; controller may use the pins |
| busy_o | output | 1 | Sequencer owns the pins |

## Verification
The non-burst sequence is run with the exit request given early. This separates a design that holds the minimum residency from one that leaves at once, and it exposes an exit window that is off by one cycle. A sequence with clk_stable_i held low shows whether the exit is gated on the clock and whether the request is remembered. An exit request given while idle, followed by an entry, tells a design that ignores stray requests from one that latches them.

Burst runs check three things: the exact command count, the spacing between commands, and the gap around the entry and exit edges. In these runs burst_mode_i is dropped right after the start, which separates a latched refresh style from a live one. An entry request given during the exit burst shows whether held requests are replayed.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AR,
    ST_AR_WAIT,
    ST_ENTER,
    ST_SELF,
    ST_EXIT
  } sr_state_e;

  typedef enum logic [1:0] {
    CMD_DESEL,
    CMD_AREF,
    CMD_SREF
  } sr_cmd_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sr_pins_t;
endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sr_burst_ctr.sv
module sr_burst_ctr #(
  parameter int N = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(N));
endmodule

// File: rtl/sr_cmd_enc.sv
module sr_cmd_enc
  import sr_seq_pkg::*;
(
  input  logic     cke_i,
  input  sr_cmd_e  cmd_i,
  output sr_pins_t pins_o
);
  always_comb begin
    pins_o.cke = cke_i;
    unique case (cmd_i)
      CMD_AREF, CMD_SREF: begin
        pins_o.cs_n  = 1'b0;
        pins_o.ras_n = 1'b0;
        pins_o.cas_n = 1'b0;
        pins_o.we_n  = 1'b1;
      end
      default: begin
        pins_o.cs_n  = 1'b1;
        pins_o.ras_n = 1'b1;
        pins_o.cas_n = 1'b1;
        pins_o.we_n  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int T_RAS     = 6,
  parameter int T_SRX     = 8,
  parameter int T_RC      = 5,
  parameter int BURST_LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_req_i,
  input  logic exit_req_i,
  input  logic burst_mode_i,
  input  logic clk_stable_i,
  output logic cke_o,
  output logic cs_no,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic ready_o,
  output logic busy_o
);
  localparam int T_EXIT = (T_SRX > T_RC) ? T_SRX : T_RC;
  localparam int T_MAX  = (T_RAS > T_EXIT) ? T_RAS : T_EXIT;
  localparam int TW     = $clog2(T_MAX + 1);

  sr_state_e state_q, state_d;
  logic      pend_enter_q, pend_exit_q;
  logic      burst_q, burst_d;
  logic      post_q, post_d;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          ctr_clr, ctr_inc, ctr_last;
  logic          start, leave_self;
  sr_cmd_e       cmd;
  sr_pins_t      pins;

  assign start      = (state_q == ST_IDLE) && (enter_req_i || pend_enter_q);
  assign leave_self = (state_q == ST_SELF) && tmr_done && clk_stable_i
                      && (pend_exit_q || exit_req_i);

  always_comb begin
    state_d  = state_q;
    burst_d  = burst_q;
    post_d   = post_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        burst_d = burst_mode_i;
        post_d  = 1'b0;
        state_d = burst_mode_i ? ST_AR : ST_ENTER;
      end
      ST_AR: begin
        state_d  = ST_AR_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RC - 2);
      end
      ST_AR_WAIT: if (tmr_done) begin
        if (!ctr_last)   state_d = ST_AR;
        else if (post_q) state_d = ST_IDLE;
        else             state_d = ST_ENTER;
      end
      ST_ENTER: begin
        state_d  = ST_SELF;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RAS - 1);
      end
      ST_SELF: if (leave_self) begin
        state_d  = ST_EXIT;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_EXIT - 1);
      end
      ST_EXIT: if (tmr_done) begin
        if (burst_q) begin
          post_d  = 1'b1;
          state_d = ST_AR;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      burst_q      <= 1'b0;
      post_q       <= 1'b0;
      pend_enter_q <= 1'b0;
      pend_exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      post_q  <= post_d;
      // entry requests outside idle wait for the return to idle
      if (start)                                 pend_enter_q <= 1'b0;
      else if (enter_req_i && state_q != ST_IDLE) pend_enter_q <= 1'b1;
      // exit requests only count once the device is in self-refresh
      if (leave_self)                            pend_exit_q <= 1'b0;
      else if (exit_req_i && (state_q == ST_ENTER || state_q == ST_SELF))
        pend_exit_q <= 1'b1;
    end
  end

  assign ctr_clr = (state_q == ST_IDLE) || (state_q == ST_EXIT);
  assign ctr_inc = (state_q == ST_AR);

  sr_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  sr_burst_ctr #(.N(BURST_LEN)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .inc_i  (ctr_inc),
    .last_o (ctr_last)
  );

  always_comb begin
    unique case (state_q)
      ST_AR:    cmd = CMD_AREF;
      ST_ENTER: cmd = CMD_SREF;
      default:  cmd = CMD_DESEL;
    endcase
  end

  sr_cmd_enc u_enc (
    .cke_i  (!(state_q == ST_ENTER || state_q == ST_SELF)),
    .cmd_i  (cmd),
    .pins_o (pins)
  );

  assign cke_o   = pins.cke;
  assign cs_no   = pins.cs_n;
  assign ras_no  = pins.ras_n;
  assign cas_no  = pins.cas_n;
  assign we_no   = pins.we_n;
  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk #(
  parameter int T_RAS = 6,
  parameter int T_SRX = 8,
  parameter int T_RC  = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_stable_i,
  input logic cke_o,
  input logic cs_no,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic ready_o,
  input logic busy_o
);
  localparam int T_EXIT = (T_SRX > T_RC) ? T_SRX : T_RC;

  logic        ar_now;
  logic [31:0] low_cnt, hi_cnt, gap_cnt;

  assign ar_now = cke_o && !cs_no && !ras_no && !cas_no && we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      hi_cnt  <= 32'(T_EXIT);
      gap_cnt <= 32'(T_RC);
    end else begin
      low_cnt <= cke_o ? '0 : low_cnt + 1;
      if (!cke_o)                  hi_cnt <= '0;
      else if (hi_cnt < T_EXIT)    hi_cnt <= hi_cnt + 1;
      if (ar_now)                  gap_cnt <= 32'd1;
      else if (gap_cnt < T_RC)     gap_cnt <= gap_cnt + 1;
    end
  end

  // R2
  entry_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_no && !ras_no && !cas_no && we_no));

  // R3
  parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> cs_no);

  // R4
  min_residency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (low_cnt >= T_RAS + 1));

  // R5
  clk_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));

  // R6
  exit_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && hi_cnt < T_EXIT) |-> (cs_no && !ready_o));

  // R7
  ar_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_now |-> (gap_cnt >= T_RC));

  // R8
  only_aref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && !cs_no) |-> (!ras_no && !cas_no && we_no));

  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o || ar_now) |-> (busy_o && !ready_o));
endmodule

bind sr_seq sr_seq_chk #(.T_RAS(T_RAS), .T_SRX(T_SRX), .T_RC(T_RC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_stable_i (clk_stable_i),
  .cke_o        (cke_o),
  .cs_no        (cs_no),
  .ras_no       (ras_no),
  .cas_no       (cas_no),
  .we_no        (we_no),
  .ready_o      (ready_o),
  .busy_o       (busy_o)
);

// File: tb/sim_sr_seq.sv
module sim_sr_seq;
  localparam int T_RAS  = 6;
  localparam int T_SRX  = 8;
  localparam int T_RC   = 5;
  localparam int BL     = 1024;
  localparam int T_EXIT = (T_SRX > T_RC) ? T_SRX : T_RC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 1'b0, exit_req = 1'b0, burst_mode = 1'b0, clk_stable = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, busy;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sr_seq #(.T_RAS(T_RAS), .T_SRX(T_SRX), .T_RC(T_RC), .BURST_LEN(BL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enter_req_i(enter_req), .exit_req_i(exit_req),
    .burst_mode_i(burst_mode), .clk_stable_i(clk_stable), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ready_o(ready), .busy_o(busy)
  );

  // pin monitor, sampled on the falling edge
  int cyc = 0, ar_cnt = 0, first_ar = 0, last_ar = 0, min_gap = 0;
  int ent_cnt = 0, ent_bad = 0, ent_cyc = 0, park_bad = 0, low_run = 0, last_low = 0;
  int rise_cyc = -1000, bad_cmd = 0, exit_bad = 0, ready_rise = 0, idle_seen = 0;
  logic prev_cke = 1'b1, prev_ready = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (cke && !cs_n) begin
        if (!ras_n && !cas_n && we_n) begin
          if (ar_cnt == 0) first_ar = cyc;
          else if (min_gap == 0 || cyc - last_ar < min_gap) min_gap = cyc - last_ar;
          last_ar = cyc;
          ar_cnt  = ar_cnt + 1;
        end else bad_cmd = bad_cmd + 1;
        if (cyc - rise_cyc < T_EXIT) exit_bad = exit_bad + 1;
      end
      if (!cke && prev_cke) begin
        ent_cnt = ent_cnt + 1;
        ent_cyc = cyc;
        low_run = 1;
        if (cs_n || ras_n || cas_n || !we_n) ent_bad = ent_bad + 1;
      end else if (!cke) begin
        low_run = low_run + 1;
        if (!cs_n) park_bad = park_bad + 1;
      end
      if (cke && !prev_cke) begin
        last_low = low_run;
        rise_cyc = cyc;
        if (ready) exit_bad = exit_bad + 1;
      end
      if (ready && !prev_ready) ready_rise = cyc;
      prev_cke   = cke;
      prev_ready = ready;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ar_cnt = 0; min_gap = 0; ent_bad = 0; park_bad = 0;
    bad_cmd = 0; exit_bad = 0; idle_seen = 0;
  endtask

  task automatic pulse_enter();
    @(negedge clk); enter_req = 1'b1;
    @(negedge clk); enter_req = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !ready; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_entries(input int n, input int lim);
    for (int i = 0; i < lim && ent_cnt < n; i++) begin
      @(negedge clk); #1;
      if (ready) idle_seen++;
    end
  endtask

  task automatic t_reset();
    #1;
    check(cke == 1 && cs_n == 1, "R1", "cke/cs after reset", {cke, cs_n}, 3);
    check(ready == 1 && busy == 0, "R1", "ready/busy after reset", {ready, busy}, 2);
  endtask

  task automatic t_plain();
    int e0 = ent_cnt;
    clear_mon();
    burst_mode = 1'b0; clk_stable = 1'b1;
    @(negedge clk); enter_req = 1'b1;
    @(negedge clk); enter_req = 1'b0; #1;
    check(ent_cnt == e0 + 1 && ent_bad == 0, "R2", "entry command next cycle", ent_cnt - e0, 1);
    check(busy && !ready, "R11", "busy during entry", {busy, ready}, 2);
    exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0; #1;
    check(!cke && cs_n, "R3", "parked after entry", {cke, cs_n}, 1);
    wait_ready(200);
    check(last_low == T_RAS + 1, "R4", "cke low cycles", last_low, T_RAS + 1);
    check(park_bad == 0, "R3", "cs low while parked", park_bad, 0);
    check(ready_rise - rise_cyc == T_EXIT, "R6", "ready after cke rise", ready_rise - rise_cyc, T_EXIT);
    check(exit_bad == 0 && ar_cnt == 0, "R6", "command in exit window", exit_bad + ar_cnt, 0);
  endtask

  task automatic t_clk_stable();
    int r0;
    clear_mon();
    clk_stable = 1'b0;
    pulse_enter();
    pulse_exit();
    r0 = rise_cyc;
    repeat (40) @(negedge clk);
    #1;
    check(!cke && rise_cyc == r0, "R5", "stays in self-refresh while clock unstable", cke, 0);
    check(cs_n == 1, "R3", "parked while waiting", cs_n, 1);
    clk_stable = 1'b1;
    @(negedge clk); #1;
    check(cke == 1, "R5", "remembered exit after clock stable", cke, 1);
    wait_ready(200);
    check(ready == 1, "R5", "returns to idle", ready, 1);
  endtask

  task automatic t_exit_ignored();
    int e0;
    clear_mon();
    pulse_exit();
    repeat (10) @(negedge clk);
    #1;
    check(cke && ready && ar_cnt == 0, "R10", "exit while idle has no effect", {cke, ready}, 3);
    e0 = ent_cnt;
    pulse_enter();
    repeat (T_RAS + 30) @(negedge clk);
    #1;
    check(!cke && ent_cnt == e0 + 1, "R10", "stray exit not remembered", cke, 0);
    pulse_exit();
    wait_ready(200);
    check(ready == 1, "R10", "normal exit after stray request", ready, 1);
  endtask

  task automatic t_burst();
    int e0 = ent_cnt;
    clear_mon();
    burst_mode = 1'b1;
    @(negedge clk); enter_req = 1'b1;
    @(negedge clk); enter_req = 1'b0; burst_mode = 1'b0;
    wait_entries(e0 + 1, 20000);
    check(ar_cnt == BL, "R7", "refresh count before entry", ar_cnt, BL);
    check(min_gap == T_RC, "R7", "refresh spacing before entry", min_gap, T_RC);
    check(ent_cyc - last_ar == T_RC, "R7", "entry gap after last refresh", ent_cyc - last_ar, T_RC);
    check(bad_cmd == 0 && ent_bad == 0, "R8", "illegal command", bad_cmd + ent_bad, 0);
    check(idle_seen == 0, "R11", "ready during entry burst", idle_seen, 0);
    clear_mon();
    pulse_exit();
    wait_ready(20000);
    check(ar_cnt == BL, "R12", "exit burst kept after style dropped", ar_cnt, BL);
    check(first_ar - rise_cyc == T_EXIT, "R7", "first refresh after cke rise", first_ar - rise_cyc, T_EXIT);
    check(ready_rise - last_ar == T_RC, "R7", "ready after last refresh", ready_rise - last_ar, T_RC);
    check(min_gap == T_RC, "R7", "refresh spacing after exit", min_gap, T_RC);
    check(bad_cmd == 0 && exit_bad == 0, "R8", "illegal command after exit", bad_cmd + exit_bad, 0);
  endtask

  task automatic t_held();
    int e0 = ent_cnt;
    burst_mode = 1'b1;
    @(negedge clk); enter_req = 1'b1;
    @(negedge clk); enter_req = 1'b0; burst_mode = 1'b0;
    wait_entries(e0 + 1, 20000);
    clear_mon();
    pulse_exit();
    for (int i = 0; i < 20000 && ar_cnt < 10; i++) @(negedge clk);
    pulse_enter();
    wait_entries(e0 + 2, 20000);
    check(ent_cnt == e0 + 2, "R9", "held entry replayed", ent_cnt - e0, 2);
    check(ar_cnt == BL, "R9", "no burst for replayed non-burst entry", ar_cnt, BL);
    pulse_exit();
    wait_ready(200);
    check(ready && ar_cnt == BL, "R9", "replayed sequence exits cleanly", ar_cnt, BL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_clk_stable();
    t_exit_ignored();
    t_burst();
    t_held();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule